// File: doc/BRIEF.md
# Two-level fixed-priority DMA request arbiter

This block picks which of eight DMA channels owns the system bus and keeps that ownership for as long as the channel's transfer mode allows. The channels form two groups of four. Channels 0 to 3 are the byte-wide group. Channels 4 to 7 are the word-wide group. Channel 4 is not wired to a peripheral. It is the slot through which the whole byte-wide group competes against channels 5 to 7.

Every channel has a request line, a mask bit and a two-bit mode field. A global disable input stops all granting. A terminal-count input closes the transfer in progress. A request that survives masking first raises the bus request. One cycle later the arbiter picks a winner and starts granted cycles, with one transfer strobe per granted cycle. The granted channel's acknowledge stays high until its mode says to release the bus. A grant on channels 0 to 3 also acknowledges channel 4, because that is the cascade path. A registered copy of every raw request line, masked or not, is also output as request status.

Top module: `dma_casc_arb`

## Requirements
- R1: After reset, `bus_req`, `xfer_stb`, every `dack` bit and every `req_pend` bit are 0.
- R2: When an unmasked request is present and the block is idle and enabled, `bus_req` rises one cycle later with no acknowledge. If a winner is still present in that cycle, the next cycle is a granted cycle. In a granted cycle `bus_req`, `xfer_stb` and the winner's `dack` are all 1. If no winner remains, the block returns to idle.
- R3: Priority is fixed and does not rotate. The byte-wide group, seen through channel 4, beats channels 5, 6 and 7. Inside each group the lowest-numbered eligible channel wins. At most one `dack` bit within each group is set.
- R4: Any grant to channels 0 to 3 also sets `dack[4]`, and `dack[4]` is never set alone. The request line of channel 4 itself is ignored. Setting `mask[4]` blocks channels 0 to 3.
- R5: A channel whose mask bit is 1 is never granted. `req_pend[c]` equals `drq[c]` from one cycle earlier, whatever the mask.
- R6: While `disable_all` is 1, no new grant starts. A granted cycle that samples `disable_all` high at its closing edge is the last one.
- R7: The mode field of channel c is `mode[2c+1:2c]`. In single mode (01) a grant lasts exactly one granted cycle and is followed by at least one idle cycle. Code 11 (cascade) on a peripheral channel acts the same way.
- R8: In demand mode (00) granted cycles continue while the channel's `drq` is 1 at each closing edge. The grant ends after the first granted cycle in which `drq` is sampled 0.
- R9: In block mode (10) granted cycles continue whatever `drq` does, until terminal count.
- R10: `tc` sampled 1 at the closing edge of a granted cycle ends the grant in every mode. The next cycle is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drq | input | 8 | Per-channel request lines |
| mask | input | 8 | Per-channel request mask, 1 = masked |
| mode | input | 16 | Two-bit mode field per channel, channel c at bits 2c+1:2c |
| disable_all | input | 1 | Global disable, 1 = no grants |
| tc | input | 1 | Terminal count of the current transfer |
| bus_req | output | 1 | Bus request, high while requesting or granted |
| dack | output | 8 | Per-channel acknowledge, bit 4 doubles as cascade acknowledge |
| xfer_stb | output | 1 | One pulse per granted transfer cycle |
| req_pend | output | 8 | Registered raw request status |

## Verification
Inputs applied in a cycle show up in every output after the next rising edge, and no output depends combinationally on an input. The request status is due one edge after the request. The bus request is also due one edge after an eligible request. The first granted cycle is due two edges after that request, and a release is due one edge after the cycle whose sampled inputs call for it. The bench drives inputs just after a rising edge. It stamps each expected output set with the cycle in which it is due. It compares at the following falling edge only when the cycle counter matches that stamp, so every check lands exactly one register stage after its stimulus.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   localparam int unsigned MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MD_DEMAND = 2'b00,
      MD_SINGLE = 2'b01,
      MD_BLOCK  = 2'b10,
      MD_CASC   = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_REQ   = 2'b01,
      ST_GRANT = 2'b10
   } arb_state_e;

endpackage

// File: rtl/dma_fixed_prio.sv
module dma_fixed_prio #(
   parameter int unsigned N  = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("dma_fixed_prio: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/dma_grant_seq.sv
module dma_grant_seq
   import dma_arb_pkg::*;
#(
   parameter int unsigned NCH = 8,
   localparam int unsigned IW = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              win_any,
   input  logic [IW-1:0]     win_ch,
   input  logic [NCH-1:0]    drq,
   input  logic [2*NCH-1:0]  mode,
   input  logic              tc,
   output logic              busy,
   output logic              active,
   output logic [IW-1:0]     cur_ch
);

   arb_state_e state_q, state_d;
   logic [IW-1:0] ch_q, ch_d;
   xfer_mode_e cur_mode;
   logic release_now;

   assign cur_mode = xfer_mode_e'(mode[{ch_q, 1'b0} +: MODE_W]);

   always_comb begin
      unique case (cur_mode)
         MD_DEMAND: release_now = !drq[ch_q];
         MD_BLOCK:  release_now = 1'b0;
         default:   release_now = 1'b1;
      endcase
      if (!en || tc) release_now = 1'b1;
   end

   always_comb begin
      state_d = state_q;
      ch_d    = ch_q;
      unique case (state_q)
         ST_IDLE: if (en && win_any) state_d = ST_REQ;
         ST_REQ: begin
            if (en && win_any) begin
               state_d = ST_GRANT;
               ch_d    = win_ch;
            end else begin
               state_d = ST_IDLE;
            end
         end
         ST_GRANT: if (release_now) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ch_q    <= '0;
      end else begin
         state_q <= state_d;
         ch_q    <= ch_d;
      end
   end

   assign busy   = (state_q != ST_IDLE);
   assign active = (state_q == ST_GRANT);
   assign cur_ch = ch_q;

   // R7: single or cascade-coded grant lasts one granted cycle
   p_single_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (cur_mode == MD_SINGLE || cur_mode == MD_CASC)) |=> !active);

   // R9: block grant holds until terminal count or disable
   p_block_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cur_mode == MD_BLOCK && !tc && en) |=> (active && $stable(cur_ch)));

   // R10: terminal count closes the grant
   p_tc_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tc) |=> !busy);

endmodule

// File: rtl/dma_casc_arb.sv
module dma_casc_arb
   import dma_arb_pkg::*;
#(
   parameter int unsigned NCH_GRP = 4,
   localparam int unsigned NCH = 2 * NCH_GRP,
   localparam int unsigned IW  = $clog2(NCH),
   localparam int unsigned GW  = $clog2(NCH_GRP)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          drq,
   input  logic [NCH-1:0]          mask,
   input  logic [MODE_W*NCH-1:0]   mode,
   input  logic                    disable_all,
   input  logic                    tc,
   output logic                    bus_req,
   output logic [NCH-1:0]          dack,
   output logic                    xfer_stb,
   output logic [NCH-1:0]          req_pend
);

   if (NCH_GRP < 2 || (NCH_GRP & (NCH_GRP - 1)) != 0) begin : g_bad_grp
      $error("dma_casc_arb: NCH_GRP must be a power of two of at least 2");
   end

   localparam int unsigned CASC = NCH_GRP;

   logic [NCH_GRP-1:0] grp_a_req, grp_b_req;
   logic               a_any, b_any;
   logic [GW-1:0]      a_idx, b_idx;
   logic [IW-1:0]      win_ch, cur_ch;
   logic               busy, active;

   assign grp_a_req = drq[NCH_GRP-1:0] & ~mask[NCH_GRP-1:0];
   assign grp_b_req = {drq[NCH-1:CASC+1] & ~mask[NCH-1:CASC+1],
                       a_any & ~mask[CASC]};

   dma_fixed_prio #(.N(NCH_GRP)) u_prio_a (
      .req (grp_a_req),
      .any (a_any),
      .idx (a_idx)
   );

   dma_fixed_prio #(.N(NCH_GRP)) u_prio_b (
      .req (grp_b_req),
      .any (b_any),
      .idx (b_idx)
   );

   assign win_ch = (b_idx == '0) ? IW'(a_idx) : IW'(CASC) + IW'(b_idx);

   dma_grant_seq #(.NCH(NCH)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (!disable_all),
      .win_any (b_any),
      .win_ch  (win_ch),
      .drq     (drq),
      .mode    (mode),
      .tc      (tc),
      .busy    (busy),
      .active  (active),
      .cur_ch  (cur_ch)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_dack
      if (c == CASC) begin : g_casc
         assign dack[c] = active && (cur_ch < IW'(CASC));
      end else begin : g_chan
         assign dack[c] = active && (cur_ch == IW'(c));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_pend <= '0;
      else        req_pend <= drq;
   end

   assign bus_req  = busy;
   assign xfer_stb = active;

   // R2: a granted cycle is always preceded by a request cycle
   p_req_before_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_stb) |-> ($past(bus_req) && !$past(xfer_stb)));

   // R3: one acknowledge per group
   p_dack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack[NCH_GRP-1:0]) && $onehot0(dack[NCH-1:CASC]));

   // R4: byte-group grant travels through the cascade acknowledge
   p_casc_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dack[CASC] == (|dack[NCH_GRP-1:0]));

   // R6: disable stops granting from the next cycle
   p_no_grant_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      disable_all |=> !xfer_stb);

endmodule

// File: tb/dma_casc_arb_tb.sv
module dma_casc_arb_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  drq = '0;
   logic [7:0]  mask = '0;
   logic [15:0] mode = '0;
   logic        disable_all = 1'b0;
   logic        tc = 1'b0;
   logic        bus_req, xfer_stb;
   logic [7:0]  dack, req_pend;

   int tests = 0;
   int fails = 0;
   int cnt = 0;

   typedef struct {
      int         due;
      string      tag;
      logic       breq;
      logic [7:0] dk;
      logic       stb;
      logic [7:0] pend;
   } item_t;

   item_t q[$];

   dma_casc_arb u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .drq         (drq),
      .mask        (mask),
      .mode        (mode),
      .disable_all (disable_all),
      .tc          (tc),
      .bus_req     (bus_req),
      .dack        (dack),
      .xfer_stb    (xfer_stb),
      .req_pend    (req_pend)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) cnt <= cnt + 1;

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cnt) begin
         item_t it;
         it = q.pop_front();
         tests++;
         if (bus_req !== it.breq || dack !== it.dk || xfer_stb !== it.stb ||
             req_pend !== it.pend) begin
            fails++;
            $display("FAIL %s cyc %0d: breq=%b dack=%h stb=%b pend=%h expected breq=%b dack=%h stb=%b pend=%h",
                     it.tag, cnt, bus_req, dack, xfer_stb, req_pend,
                     it.breq, it.dk, it.stb, it.pend);
         end
      end
   end

   task automatic step(input logic [7:0] d, input logic [7:0] m, input logic dis,
                       input logic t, input logic eb, input logic [7:0] ed,
                       input logic es, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      drq = d; mask = m; disable_all = dis; tc = t;
      it.due = cnt + 1; it.tag = tag; it.breq = eb; it.dk = ed;
      it.stb = es; it.pend = d;
      q.push_back(it);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      report();
   end

   initial begin
      // modes: ch0=11 ch1=01 ch2=01 ch3=01 ch4=00 ch5=01 ch6=10 ch7=00
      mode = 16'h2457;
      #(CLK_PERIOD * 3 + 2);
      rst_n = 1'b1;
      @(negedge clk);
      tests++; // R1
      if (bus_req !== 1'b0 || dack !== 8'h00 || xfer_stb !== 1'b0 || req_pend !== 8'h00) begin
         fails++;
         $display("FAIL R1: breq=%b dack=%h stb=%b pend=%h expected 0 00 0 00",
                  bus_req, dack, xfer_stb, req_pend);
      end

      // R2 / R7: single-mode channel 2 repeated
      step(8'h04, 8'h00, 0, 0, 1, 8'h00, 0, "R2");
      step(8'h04, 8'h00, 0, 0, 1, 8'h14, 1, "R2");
      step(8'h04, 8'h00, 0, 0, 0, 8'h00, 0, "R7");
      step(8'h04, 8'h00, 0, 0, 1, 8'h00, 0, "R7");
      step(8'h04, 8'h00, 0, 0, 1, 8'h14, 1, "R7");
      step(8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R7");
      // R3 priority, R5 mask, R4 cascade mask
      step(8'h2A, 8'h00, 0, 0, 1, 8'h00, 0, "R3");
      step(8'h2A, 8'h00, 0, 0, 1, 8'h12, 1, "R3");
      step(8'h2A, 8'h02, 0, 0, 0, 8'h00, 0, "R7");
      step(8'h2A, 8'h02, 0, 0, 1, 8'h00, 0, "R5");
      step(8'h2A, 8'h02, 0, 0, 1, 8'h18, 1, "R5");
      step(8'h2A, 8'h10, 0, 0, 0, 8'h00, 0, "R7");
      step(8'h2A, 8'h10, 0, 0, 1, 8'h00, 0, "R4");
      step(8'h2A, 8'h10, 0, 0, 1, 8'h20, 1, "R4");
      step(8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R7");
      // R4: channel 4 own request ignored; R5: masked request only in status
      step(8'h10, 8'h00, 0, 0, 0, 8'h00, 0, "R4");
      step(8'h20, 8'h20, 0, 0, 0, 8'h00, 0, "R5");
      // R6: disabled, no request raised
      step(8'h02, 8'h00, 1, 0, 0, 8'h00, 0, "R6");
      step(8'h02, 8'h00, 1, 0, 0, 8'h00, 0, "R6");
      step(8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R6");
      // R9 block channel 6, R10 terminal count
      step(8'h40, 8'h00, 0, 0, 1, 8'h00, 0, "R9");
      step(8'h40, 8'h00, 0, 0, 1, 8'h40, 1, "R9");
      step(8'h00, 8'h00, 0, 0, 1, 8'h40, 1, "R9");
      step(8'h00, 8'h00, 0, 0, 1, 8'h40, 1, "R9");
      step(8'h00, 8'h00, 0, 1, 0, 8'h00, 0, "R10");
      // R8 demand channel 7
      step(8'h80, 8'h00, 0, 0, 1, 8'h00, 0, "R8");
      step(8'h80, 8'h00, 0, 0, 1, 8'h80, 1, "R8");
      step(8'h80, 8'h00, 0, 0, 1, 8'h80, 1, "R8");
      step(8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R8");
      // R10 terminal count in demand mode
      step(8'h80, 8'h00, 0, 0, 1, 8'h00, 0, "R10");
      step(8'h80, 8'h00, 0, 0, 1, 8'h80, 1, "R10");
      step(8'h80, 8'h00, 0, 1, 0, 8'h00, 0, "R10");
      // R6 disable ends a block grant
      step(8'h40, 8'h00, 0, 0, 1, 8'h00, 0, "R6");
      step(8'h40, 8'h00, 0, 0, 1, 8'h40, 1, "R6");
      step(8'h40, 8'h00, 1, 0, 0, 8'h00, 0, "R6");
      step(8'h40, 8'h00, 1, 0, 0, 8'h00, 0, "R6");
      // R7 cascade code on channel 0 acts as single
      step(8'h01, 8'h00, 0, 0, 1, 8'h00, 0, "R7");
      step(8'h01, 8'h00, 0, 0, 1, 8'h11, 1, "R7");
      step(8'h01, 8'h00, 0, 0, 0, 8'h00, 0, "R7");
      // R3 lowest of channels 5..7
      step(8'hE0, 8'h00, 0, 0, 1, 8'h00, 0, "R3");
      step(8'hE0, 8'h00, 0, 0, 1, 8'h20, 1, "R3");
      step(8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R3");
      // R2 request gone before grant
      step(8'h08, 8'h00, 0, 0, 1, 8'h00, 0, "R2");
      step(8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R2");
      step(8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R1");

      repeat (4) @(posedge clk);
      @(negedge clk);
      if (q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      report();
   end

endmodule